// File: doc/BRIEF.md
# Transfer Buffer with Length Check

This block is the 512-byte staging buffer that sits between a processor and the card side of a card host controller. Software moves data through a 32-bit programmed-I/O window: a word write pushes four bytes and a word read pops up to four. The byte order is big-endian, so the oldest byte travels in bits 31..24. A simple byte-stream port stands in for the card-side engine. Bytes enter the buffer when data comes from the card and leave it when data goes to the card.

A transfer begins when software writes the command-execute word. The block decodes three fields from that word: the byte length, the command code and the large-buffer select. It then opens the card port and counts the bytes that cross that port. When the card side signals end of transfer, the count is compared with the commanded length, and any difference raises a sticky mismatch flag. A window read while the buffer holds nothing raises a sticky underrun flag. Both flags stay set until software acknowledges them. Occupancy and an empty indication are always visible.

Top module: `xfer_fifo_top`

## Requirements
- R1: After reset, the occupancy is 0, the empty output is 1, the underrun and mismatch flags are 0, no transfer is active, and the card port neither accepts nor offers bytes.
- R2: A command write decodes three fields: bits 25..16 give the transfer length, bits 31..28 give the command code and bit 26 gives the large-buffer select. The decoded fields appear on the outputs one cycle after the write, and the transfer becomes active. All other bits of the word are ignored.
- R3: A window write stores four bytes: bits 31..24 first, then 23..16, then 15..8, then 7..0. The card port hands out bytes in the order they were stored.
- R4: A window read returns, one cycle later, up to four of the oldest bytes, with the oldest in bits 31..24. When fewer than four bytes are held, the missing low-order bytes read as zero, and only the bytes that were held are removed.
- R5: The buffer holds at most 512 bytes. A window write made when fewer than 4 bytes are free is dropped whole. The card port does not accept bytes while the buffer is full.
- R6: A window read of an empty buffer returns 0, leaves the occupancy unchanged and sets the underrun flag.
- R7: The underrun flag (acknowledge bit 0) and the mismatch flag (acknowledge bit 1) stay set until their acknowledge bit is driven. A new setting event in the same cycle as the acknowledge wins.
- R8: When end of transfer is signalled during an active transfer with the large buffer selected, the mismatch flag is set if the number of card-port bytes since the command write differs from the commanded length. Any end-of-transfer signal ends the active transfer.
- R9: The card port accepts or offers bytes only while a transfer is active with the large buffer selected.
- R10: The occupancy output counts the bytes held, and the empty output is 1 exactly when that count is 0.
- R11: In any cycle with a window write, the card port does not accept a byte. In any cycle with a window read, the card port does not offer a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command-execute write strobe |
| cmd_wdata_i | input | 32 | Command-execute word |
| pio_we_i | input | 1 | Window write strobe |
| pio_wdata_i | input | 32 | Window write word, big-endian |
| pio_re_i | input | 1 | Window read strobe |
| pio_rdata_o | output | 32 | Window read word, valid the cycle after the strobe |
| irq_ack_i | input | 2 | Flag acknowledge: bit 0 underrun, bit 1 mismatch |
| underrun_o | output | 1 | Sticky underrun flag |
| mismatch_o | output | 1 | Sticky length mismatch flag |
| empty_o | output | 1 | Buffer empty |
| count_o | output | 10 | Bytes held |
| xfer_len_o | output | 10 | Decoded transfer length |
| xfer_code_o | output | 4 | Decoded command code |
| big_sel_o | output | 1 | Decoded large-buffer select |
| xfer_active_o | output | 1 | Transfer in progress |
| card_in_valid_i | input | 1 | Card side offers a byte |
| card_in_data_i | input | 8 | Byte from card side |
| card_in_ready_o | output | 1 | Buffer accepts a card byte |
| card_out_valid_o | output | 1 | Buffer offers a byte to card side |
| card_out_data_o | output | 8 | Byte to card side |
| card_out_ready_i | input | 1 | Card side takes the offered byte |
| card_done_i | input | 1 | End of transfer pulse |

## Verification
The bench writes random words through the window and drains them byte by byte through the card port. This separates a correct big-endian split from a swapped or rotated one. It also pushes random runs of 1 to 6 bytes from the card side and reads them back as words, so partial words show whether zero padding and partial removal are correct. Directed cases cover:
- reads of an empty buffer;
- a complete fill to 512 bytes, followed by one dropped write;
- commands with the large-buffer select cleared;
- lengths that match and lengths that are off by one;
- an acknowledge in the same cycle as a new underrun.

Together these tell a wrong compare or a missing gate apart from a wrong priority between set and clear.

// File: rtl/xfer_fifo_pkg.sv
package xfer_fifo_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned WORD_W     = BYTE_W * WORD_BYTES;
  localparam int unsigned LEN_LSB    = 16;
  localparam int unsigned LEN_W      = 10;
  localparam int unsigned BIG_BIT    = 26;
  localparam int unsigned CODE_LSB   = 28;
  localparam int unsigned CODE_W     = 4;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic              big;
    logic [LEN_W-1:0]  len;
  } xfer_cmd_t;

  function automatic xfer_cmd_t decode_cmd(input logic [WORD_W-1:0] w);
    xfer_cmd_t c;
    c.len  = w[LEN_LSB +: LEN_W];
    c.big  = w[BIG_BIT];
    c.code = w[CODE_LSB +: CODE_W];
    return c;
  endfunction
endpackage

// File: rtl/xfer_byte_store.sv
module xfer_byte_store
  import xfer_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned WB    = WORD_BYTES,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = PTR_W + 1,
  localparam int unsigned NW    = $clog2(WB + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NW-1:0]            push_n_i,
  input  logic [WB-1:0][BYTE_W-1:0] push_data_i,
  input  logic [NW-1:0]            pop_n_i,
  output logic [WB-1:0][BYTE_W-1:0] head_data_o,
  output logic [CNT_W-1:0]         count_o
);
  // DEPTH must be a power of two: pointers wrap naturally
  logic [BYTE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rd_ptr_q, wr_ptr_q;
  logic [CNT_W-1:0]  count_q;

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < int'(WB); i++) begin
      if (i < int'(push_n_i)) mem[wr_ptr_q + PTR_W'(i)] <= push_data_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_q + PTR_W'(push_n_i);
      rd_ptr_q <= rd_ptr_q + PTR_W'(pop_n_i);
      count_q  <= count_q + CNT_W'(push_n_i) - CNT_W'(pop_n_i);
    end
  end

  for (genvar g = 0; g < int'(WB); g++) begin : g_head
    assign head_data_o[g] = (g < int'(count_q)) ? mem[rd_ptr_q + PTR_W'(g)] : '0;
  end

  assign count_o = count_q;

  p_count_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));
  p_pop_in_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(pop_n_i) <= int'(count_q));
  p_push_fits_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(count_q) + int'(push_n_i) <= int'(DEPTH));
endmodule

// File: rtl/xfer_pio_window.sv
module xfer_pio_window
  import xfer_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned WB    = WORD_BYTES,
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1,
  localparam int unsigned NW    = $clog2(WB + 1),
  localparam int unsigned W_W   = WB * BYTE_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [W_W-1:0]            wr_data_i,
  input  logic                      rd_en_i,
  input  logic [CNT_W-1:0]          count_i,
  input  logic [WB-1:0][BYTE_W-1:0] head_data_i,
  input  logic                      underrun_clr_i,
  output logic                      wr_accept_o,
  output logic [WB-1:0][BYTE_W-1:0] wr_bytes_o,
  output logic [NW-1:0]             rd_pop_n_o,
  output logic [W_W-1:0]            rd_data_o,
  output logic                      underrun_o
);
  logic [W_W-1:0] head_word;
  logic           underrun_q;
  logic           empty_read;

  // big-endian: slot 0 (oldest) maps to the top byte lane
  for (genvar g = 0; g < int'(WB); g++) begin : g_lane
    assign wr_bytes_o[g] = wr_data_i[W_W-1-BYTE_W*g -: BYTE_W];
    assign head_word[W_W-1-BYTE_W*g -: BYTE_W] = head_data_i[g];
  end

  assign wr_accept_o = wr_en_i && (int'(count_i) + int'(WB) <= int'(DEPTH));
  assign empty_read  = rd_en_i && (count_i == '0);

  always_comb begin
    rd_pop_n_o = '0;
    if (rd_en_i) begin
      rd_pop_n_o = (int'(count_i) >= int'(WB)) ? NW'(WB) : NW'(count_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o  <= '0;
      underrun_q <= 1'b0;
    end else begin
      if (rd_en_i) rd_data_o <= head_word;
      if (empty_read)          underrun_q <= 1'b1;
      else if (underrun_clr_i) underrun_q <= 1'b0;
    end
  end

  assign underrun_o = underrun_q;

  p_underrun_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && count_i == '0) |=> underrun_o);
  p_empty_read_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && count_i == '0) |=> (rd_data_o == '0));
  p_underrun_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underrun_o && !underrun_clr_i) |=> underrun_o);
  p_underrun_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underrun_clr_i && !rd_en_i) |=> !underrun_o);
endmodule

// File: rtl/xfer_len_check.sv
module xfer_len_check
  import xfer_fifo_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic [WORD_W-1:0] cmd_wdata_i,
  input  logic              card_beat_i,
  input  logic              card_done_i,
  input  logic              mismatch_clr_i,
  output xfer_cmd_t         cmd_o,
  output logic              active_o,
  output logic              mismatch_o
);
  localparam int unsigned BC_W = LEN_W + 1;

  xfer_cmd_t       cmd_q;
  logic            active_q, mismatch_q, bad_len;
  logic [BC_W-1:0] beats_q;

  assign bad_len = card_done_i && active_q && cmd_q.big &&
                   (beats_q != {1'b0, cmd_q.len});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q      <= '0;
      active_q   <= 1'b0;
      beats_q    <= '0;
      mismatch_q <= 1'b0;
    end else begin
      if (cmd_we_i) begin
        cmd_q    <= decode_cmd(cmd_wdata_i);
        active_q <= 1'b1;
        beats_q  <= '0;
      end else begin
        if (card_done_i) active_q <= 1'b0;
        // saturate so an overlong transfer never wraps into a match
        if (card_beat_i && beats_q != '1) beats_q <= beats_q + 1'b1;
      end
      if (bad_len)             mismatch_q <= 1'b1;
      else if (mismatch_clr_i) mismatch_q <= 1'b0;
    end
  end

  assign cmd_o      = cmd_q;
  assign active_o   = active_q;
  assign mismatch_o = mismatch_q;

  p_cmd_starts_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_i |=> active_o);
  p_done_ends_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (card_done_i && !cmd_we_i) |=> !active_o);
  p_mismatch_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_len |=> mismatch_o);
  p_mismatch_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mismatch_o && !mismatch_clr_i) |=> mismatch_o);
endmodule

// File: rtl/xfer_fifo_top.sv
module xfer_fifo_top
  import xfer_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 512,
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1,
  localparam int unsigned NW    = $clog2(WORD_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic [WORD_W-1:0] cmd_wdata_i,
  input  logic              pio_we_i,
  input  logic [WORD_W-1:0] pio_wdata_i,
  input  logic              pio_re_i,
  output logic [WORD_W-1:0] pio_rdata_o,
  input  logic [1:0]        irq_ack_i,
  output logic              underrun_o,
  output logic              mismatch_o,
  output logic              empty_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [LEN_W-1:0]  xfer_len_o,
  output logic [CODE_W-1:0] xfer_code_o,
  output logic              big_sel_o,
  output logic              xfer_active_o,
  input  logic              card_in_valid_i,
  input  logic [BYTE_W-1:0] card_in_data_i,
  output logic              card_in_ready_o,
  output logic              card_out_valid_o,
  output logic [BYTE_W-1:0] card_out_data_o,
  input  logic              card_out_ready_i,
  input  logic              card_done_i
);
  logic [NW-1:0]                    push_n, pop_n, pio_pop_n;
  logic [WORD_BYTES-1:0][BYTE_W-1:0] push_data, pio_bytes, head_data;
  logic [CNT_W-1:0]                 count;
  logic                             pio_accept, card_en, card_push, card_pop;
  xfer_cmd_t                        cmd;
  logic                             active;

  xfer_byte_store #(.DEPTH(DEPTH), .WB(WORD_BYTES)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_n_i    (push_n),
    .push_data_i (push_data),
    .pop_n_i     (pop_n),
    .head_data_o (head_data),
    .count_o     (count)
  );

  xfer_pio_window #(.DEPTH(DEPTH), .WB(WORD_BYTES)) u_pio (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .wr_en_i        (pio_we_i),
    .wr_data_i      (pio_wdata_i),
    .rd_en_i        (pio_re_i),
    .count_i        (count),
    .head_data_i    (head_data),
    .underrun_clr_i (irq_ack_i[0]),
    .wr_accept_o    (pio_accept),
    .wr_bytes_o     (pio_bytes),
    .rd_pop_n_o     (pio_pop_n),
    .rd_data_o      (pio_rdata_o),
    .underrun_o     (underrun_o)
  );

  xfer_len_check u_len (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cmd_we_i       (cmd_we_i),
    .cmd_wdata_i    (cmd_wdata_i),
    .card_beat_i    (card_push || card_pop),
    .card_done_i    (card_done_i),
    .mismatch_clr_i (irq_ack_i[1]),
    .cmd_o          (cmd),
    .active_o       (active),
    .mismatch_o     (mismatch_o)
  );

  // card port is gated by the transfer and yields to the window
  assign card_en          = active && cmd.big;
  assign card_in_ready_o  = card_en && !pio_we_i && (count < CNT_W'(DEPTH));
  assign card_out_valid_o = card_en && !pio_re_i && (count != '0);
  assign card_out_data_o  = head_data[0];
  assign card_push        = card_in_valid_i && card_in_ready_o;
  assign card_pop         = card_out_valid_o && card_out_ready_i;

  always_comb begin
    push_n    = '0;
    push_data = pio_bytes;
    if (pio_accept) begin
      push_n = NW'(WORD_BYTES);
    end else if (card_push) begin
      push_n       = NW'(1);
      push_data[0] = card_in_data_i;
    end
  end

  assign pop_n = pio_re_i ? pio_pop_n : (card_pop ? NW'(1) : '0);

  assign count_o       = count;
  assign empty_o       = (count == '0);
  assign xfer_len_o    = cmd.len;
  assign xfer_code_o   = cmd.code;
  assign big_sel_o     = cmd.big;
  assign xfer_active_o = active;

  p_empty_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pio_re_i && empty_o && !pio_we_i && !card_in_valid_i) |=> empty_o);
  p_write_grows_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pio_accept && !pio_re_i && !card_pop) |=> (count_o == $past(count_o) + CNT_W'(WORD_BYTES)));
  p_idle_port_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xfer_active_o && !cmd_we_i) |=> (!card_in_ready_o && !card_out_valid_o));
endmodule

// File: tb/xfer_fifo_top_test.sv
module xfer_fifo_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 0, pio_we = 0, pio_re = 0;
  logic [31:0] cmd_wdata = 0, pio_wdata = 0, pio_rdata;
  logic [1:0]  irq_ack = 0;
  logic        underrun, mismatch, empty, big_sel, active;
  logic [9:0]  count, xfer_len;
  logic [3:0]  xfer_code;
  logic        cin_valid = 0, cin_ready, cout_valid, cout_ready = 0, done = 0;
  logic [7:0]  cin_data = 0, cout_data;

  int n_chk = 0, n_fail = 0;
  byte unsigned q[$];

  always #5 clk = ~clk;

  xfer_fifo_top uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_we_i(cmd_we), .cmd_wdata_i(cmd_wdata),
    .pio_we_i(pio_we), .pio_wdata_i(pio_wdata),
    .pio_re_i(pio_re), .pio_rdata_o(pio_rdata),
    .irq_ack_i(irq_ack), .underrun_o(underrun), .mismatch_o(mismatch),
    .empty_o(empty), .count_o(count), .xfer_len_o(xfer_len),
    .xfer_code_o(xfer_code), .big_sel_o(big_sel), .xfer_active_o(active),
    .card_in_valid_i(cin_valid), .card_in_data_i(cin_data), .card_in_ready_o(cin_ready),
    .card_out_valid_o(cout_valid), .card_out_data_o(cout_data),
    .card_out_ready_i(cout_ready), .card_done_i(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cmd_word(input logic [3:0] code, input logic big,
                                           input logic [9:0] len, input logic [31:0] junk);
    logic [31:0] w = junk & 32'h0800_FFFF;  // only bits the decoder ignores
    w[31:28] = code; w[26] = big; w[25:16] = len;
    return w;
  endfunction

  function automatic logic [31:0] model_pop_word();
    logic [31:0] w = 0;
    for (int i = 0; i < 4; i++)
      if (q.size() > 0) w[31-8*i -: 8] = q.pop_front();
    return w;
  endfunction

  task automatic step(); @(posedge clk); @(negedge clk); endtask

  task automatic do_cmd(input logic [31:0] w);
    cmd_we = 1; cmd_wdata = w; step(); cmd_we = 0;
  endtask

  task automatic do_write(input logic [31:0] w);
    pio_we = 1; pio_wdata = w; step(); pio_we = 0;
  endtask

  task automatic do_read(output logic [31:0] w);
    pio_re = 1; step(); pio_re = 0; w = pio_rdata;
  endtask

  task automatic card_push(input byte unsigned b);
    cin_valid = 1; cin_data = b; step(); cin_valid = 0;
  endtask

  task automatic card_pull(output logic [7:0] b, output logic v);
    v = cout_valid; b = cout_data; cout_ready = 1; step(); cout_ready = 0;
  endtask

  task automatic do_done(); done = 1; step(); done = 0; endtask
  task automatic do_ack(input logic [1:0] m); irq_ack = m; step(); irq_ack = 0; endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] w, e, c;
    logic [7:0]  b;
    logic        v;
    int unsigned seed = 32'h5eed_0c1a;
    void'($urandom(seed));

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", 32'(count), 0);
    chk("R1 empty", 32'(empty), 1);
    chk("R1 flags", {30'd0, underrun, mismatch}, 0);
    chk("R1 active", 32'(active), 0);
    chk("R1/R9 card idle", {30'd0, cin_ready, cout_valid}, 0);

    // R6 empty read
    do_read(w);
    chk("R6 empty read data", w, 0);
    chk("R6 count unchanged", 32'(count), 0);
    chk("R6 underrun set", 32'(underrun), 1);
    step();
    chk("R7 underrun sticky", 32'(underrun), 1);
    do_ack(2'b10);
    chk("R7 wrong ack bit ignored", 32'(underrun), 1);
    do_ack(2'b01);
    chk("R7 underrun cleared", 32'(underrun), 0);
    // R7 set wins over ack
    irq_ack = 2'b01; do_read(w); irq_ack = 0;
    chk("R7 set beats ack", 32'(underrun), 1);
    do_ack(2'b01);

    // R2 decode
    c = cmd_word(4'hA, 1'b1, 10'd8, $urandom());
    do_cmd(c);
    chk("R2 len", 32'(xfer_len), 8);
    chk("R2 code", 32'(xfer_code), 32'hA);
    chk("R2 big", 32'(big_sel), 1);
    chk("R2 active", 32'(active), 1);

    // R3 write two random words, drain through card port
    for (int k = 0; k < 2; k++) begin
      w = $urandom();
      do_write(w);
      for (int i = 0; i < 4; i++) q.push_back(w[31-8*i -: 8]);
    end
    chk("R10 count after writes", 32'(count), 8);
    chk("R10 not empty", 32'(empty), 0);
    for (int i = 0; i < 8; i++) begin
      card_pull(b, v);
      chk("R3 card out valid", 32'(v), 1);
      chk("R3 byte order", 32'(b), 32'(q.pop_front()));
    end
    chk("R10 empty after drain", 32'(empty), 1);
    do_done();
    chk("R8 exact length no mismatch", 32'(mismatch), 0);
    chk("R8 done ends transfer", 32'(active), 0);

    // R4 partial word and R8 off-by-one
    do_cmd(cmd_word(4'h3, 1'b1, 10'd5, 0));
    for (int i = 0; i < 6; i++) begin
      b = 8'($urandom());
      card_push(b); q.push_back(b);
    end
    do_read(w); e = model_pop_word();
    chk("R4 full word", w, e);
    chk("R4 count after full read", 32'(count), 2);
    do_read(w); e = model_pop_word();
    chk("R4 zero padded", w, e);
    chk("R4 count after partial read", 32'(count), 0);
    chk("R6 partial read no underrun", 32'(underrun), 0);
    do_done();
    chk("R8 length mismatch", 32'(mismatch), 1);
    step();
    chk("R7 mismatch sticky", 32'(mismatch), 1);
    do_ack(2'b10);
    chk("R7 mismatch cleared", 32'(mismatch), 0);

    // R9 small buffer select keeps card port closed
    do_cmd(cmd_word(4'h5, 1'b0, 10'd4, 0));
    w = $urandom(); do_write(w);
    for (int i = 0; i < 4; i++) q.push_back(w[31-8*i -: 8]);
    cin_valid = 1; #1;
    chk("R9 no card accept", 32'(cin_ready), 0);
    chk("R9 no card offer", 32'(cout_valid), 0);
    step(); cin_valid = 0;
    chk("R9 card byte ignored", 32'(count), 4);
    do_done();
    chk("R8 no check without big", 32'(mismatch), 0);
    do_read(w); e = model_pop_word();
    chk("R3 window round trip", w, e);

    // R11 arbitration
    do_cmd(cmd_word(4'h1, 1'b1, 10'd0, 0));
    w = $urandom(); do_write(w);
    for (int i = 0; i < 4; i++) q.push_back(w[31-8*i -: 8]);
    pio_re = 1; #1;
    chk("R11 read blocks card offer", 32'(cout_valid), 0);
    step(); pio_re = 0; e = model_pop_word();
    chk("R11 read data", pio_rdata, e);
    pio_we = 1; pio_wdata = $urandom(); #1;
    chk("R11 write blocks card accept", 32'(cin_ready), 0);
    step(); pio_we = 0;
    for (int i = 0; i < 4; i++) q.push_back(pio_wdata[31-8*i -: 8]);
    do_read(w); e = model_pop_word();
    chk("R11 write data", w, e);

    // R5 fill to capacity
    for (int k = 0; k < 128; k++) begin
      w = $urandom(); do_write(w);
      for (int i = 0; i < 4; i++) q.push_back(w[31-8*i -: 8]);
    end
    chk("R5 full count", 32'(count), 512);
    chk("R5 full card not ready", 32'(cin_ready), 0);
    do_write(32'hDEAD_BEEF);
    chk("R5 overflow write dropped", 32'(count), 512);
    for (int k = 0; k < 128; k++) begin
      do_read(w); e = model_pop_word();
      chk("R5 readback", w, e);
    end
    chk("R10 empty after full drain", 32'(empty), 1);
    do_done();

    // random card-in / window-out runs
    for (int r = 0; r < 12; r++) begin
      int n = 1 + int'($urandom() % 6);
      do_cmd(cmd_word(4'($urandom()), 1'b1, 10'(n), $urandom()));
      for (int i = 0; i < n; i++) begin
        b = 8'($urandom()); card_push(b); q.push_back(b);
      end
      chk("R10 random count", 32'(count), 32'(n));
      while (q.size() > 0) begin
        do_read(w); e = model_pop_word();
        chk("R4 random read", w, e);
      end
      do_done();
      chk("R8 random exact", 32'(mismatch), 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule